// File: doc/BRIEF.md
# Prescaled Multi-Timer Unit with Watchdog

This block is a timer peripheral with a register read/write port. A single programmable prescaler divides the system clock into a tick. For example, a reload of 99 gives a 1 MHz tick from a 100 MHz clock. A parameterised number of down-counting timers (1 to 7) consume that tick. Each timer has its own counter, reload register and control word. When a timer underflows, it sets a pending flag. It can pulse an interrupt line, and it then either reloads or stops.

Interrupt lines are allocated from a configured base number. Timer i drives line `IRQ_BASE+i`, or, when separate interrupts are turned off, every timer drives line `IRQ_BASE`. When the watchdog option is on, the last timer comes out of reset loaded with a time-out value and already enabled, so it counts without software action. Its first underflow raises a watchdog output that only a reset clears. Software writes registers through a single-cycle write strobe and reads them through a combinational read port. Adapting this port to a bus protocol is left to the surrounding logic.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset the prescaler reload and count equal `PRESC_RST`, and all timer registers and pending flags are zero. The exception is the watchdog timer (last timer, with `WDOG_EN`), whose count and reload equal `WDOG_INIT` and whose control reads enable=1. `irq_o` and `wdog_o` are low.
- R2: The prescaler count (read address 1) decrements once per clock. In any cycle where it is zero, a tick is issued and the count is reloaded from the prescaler reload register (read/write address 0). This gives one tick every reload+1 cycles.
- R3: Timer i has its count at address 4*(i+1). While enabled (control bit 0), the count decrements by one on each tick. While disabled, it holds its value.
- R4: An enabled timer whose count is zero on a tick underflows. If auto-reload (control bit 1) is set, the count is loaded from the reload register at address 4*(i+1)+1 and the timer keeps running.
- R5: On underflow with auto-reload clear, the timer clears its enable bit and its count stays at zero.
- R6: Underflow sets the pending flag, which reads as control bit 4 at address 4*(i+1)+2. Writing the control word with bit 4 set clears the flag, but an underflow in the same cycle wins.
- R7: With separate interrupts, an underflow with interrupt-enable (control bit 2) set gives a one-cycle pulse on `irq_o[IRQ_BASE+i]` in the cycle after the tick. With interrupt-enable clear, no pulse is given.
- R8: With separate interrupts turned off, every timer's pulse appears on `irq_o[IRQ_BASE]`, and no other line is driven.
- R9: Writing control bit 3 copies the reload register into the count on the next clock edge. Writing the count address sets the count directly.
- R10: `wdog_o` rises in the cycle after the watchdog timer underflows and stays high until reset, regardless of later register writes.
- R11: A count or load write in the same cycle as a tick takes precedence over the decrement or reload. A control write takes precedence over the auto-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq_o | output | IRQ_LINES | Interrupt pulse lines |
| wdog_o | output | 1 | Sticky watchdog time-out flag |

## Verification
Register writes land at the clock edge that samples the strobe, so read data reflects them half a cycle later. Underflow effects (pending, interrupt pulse, reload or stop, and the watchdog flag) appear one edge after the cycle in which the prescaler count reads zero. The bench keeps a behavioural model that it advances at each rising edge using the same inputs the design sees. On every falling edge it compares the read data, the interrupt lines of both a separate-line instance and a shared-line instance, and the watchdog flag against that model. Inputs change one time unit after the rising edge, and explicit read checks are placed after the falling edge, so no comparison races a register update.

// File: rtl/mtu_pkg.sv
// Shared types for the multi-timer unit.
// Assumes: control word bits are en=0, auto-reload=1, irq-enable=2,
// load strobe=3, pending=4.
package mtu_pkg;
    typedef struct packed {
        logic irq_en;
        logic auto_rl;
        logic en;
    } tmr_ctrl_t;

    localparam int CB_EN   = 0;
    localparam int CB_AUTO = 1;
    localparam int CB_IE   = 2;
    localparam int CB_LOAD = 3;
    localparam int CB_PEND = 4;
endpackage

// File: rtl/mtu_prescaler.sv
// Shared prescaler: counts down from its reload value and issues a one-cycle
// tick whenever the count is zero, reloading in that same cycle.
// Assumes: reload writes take effect on the next edge; the reload in a tick
// cycle uses the register value before the write.
module mtu_prescaler #(
    parameter int PW         = 8,
    parameter int RST_RELOAD = 99
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_we,
    input  logic [PW-1:0] reload_wdata,
    output logic [PW-1:0] reload_q,
    output logic [PW-1:0] count_q,
    output logic          tick
);
    assign tick = (count_q == '0);

    // Holds the software-written reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= PW'(RST_RELOAD);
        else if (reload_we) reload_q <= reload_wdata;
    end

    // Down-counter that wraps to the reload value on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= PW'(RST_RELOAD);
        else if (tick) count_q <= reload_q;
        else           count_q <= count_q - 1'b1;
    end

    // R2
    psc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/mtu_timer_chan.sv
// One down-counting timer channel driven by the shared tick.
// Assumes: at most one register write per cycle; register writes outrank
// tick effects except the pending flag, where underflow wins.
module mtu_timer_chan
    import mtu_pkg::*;
#(
    parameter int          TW        = 16,
    parameter bit          IS_WDOG   = 1'b0,
    parameter int unsigned WDOG_INIT = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_we,
    input  logic          rl_we,
    input  logic          ctrl_we,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] cnt_q,
    output logic [TW-1:0] rl_q,
    output tmr_ctrl_t     ctrl_q,
    output logic          pend_q,
    output logic          irq_pulse,
    output logic          uf_now
);
    localparam logic [TW-1:0] RST_VAL = IS_WDOG ? TW'(WDOG_INIT) : '0;
    localparam tmr_ctrl_t RST_CTRL = '{irq_en: 1'b0, auto_rl: 1'b0, en: IS_WDOG};

    assign uf_now = tick && ctrl_q.en && (cnt_q == '0);

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rl_q <= RST_VAL;
        else if (rl_we) rl_q <= wdata;
    end

    // Control word; a one-shot underflow drops the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= RST_CTRL;
        else if (ctrl_we)                   ctrl_q <= '{irq_en: wdata[CB_IE], auto_rl: wdata[CB_AUTO], en: wdata[CB_EN]};
        else if (uf_now && !ctrl_q.auto_rl) ctrl_q.en <= 1'b0;
    end

    // Counter: direct write, load strobe, then tick-driven count or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= RST_VAL;
        else if (cnt_we)                    cnt_q <= wdata;
        else if (ctrl_we && wdata[CB_LOAD]) cnt_q <= rl_q;
        else if (tick && ctrl_q.en) begin
            if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
            else if (ctrl_q.auto_rl) cnt_q <= rl_q;
        end
    end

    // Pending flag: set on underflow, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pend_q <= 1'b0;
        else if (uf_now)                    pend_q <= 1'b1;
        else if (ctrl_we && wdata[CB_PEND]) pend_q <= 1'b0;
    end

    // One-cycle interrupt pulse after an enabled underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= uf_now && ctrl_q.irq_en;
    end

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !cnt_we && !ctrl_we) |=> $stable(cnt_q));
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl_q.en && cnt_q == '0 && !ctrl_q.auto_rl && !ctrl_we) |=> !ctrl_q.en);
    // R6
    pend_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> pend_q);
endmodule

// File: rtl/multi_timer_unit.sv
// Multi-timer unit top: shared prescaler, NUM_TIMERS channels, register
// decode, interrupt line mapping and sticky watchdog flag.
// Assumes: address map 0 prescaler reload, 1 prescaler count, timer i at
// 4*(i+1) count, +1 reload, +2 control; IRQ_BASE+NUM_TIMERS <= IRQ_LINES.
module multi_timer_unit
    import mtu_pkg::*;
#(
    parameter int          PRESC_W    = 8,
    parameter int          PRESC_RST  = 99,
    parameter int          NUM_TIMERS = 3,
    parameter int          TIMER_W    = 16,
    parameter int          IRQ_LINES  = 16,
    parameter int          IRQ_BASE   = 4,
    parameter bit          SEP_IRQ    = 1'b1,
    parameter bit          WDOG_EN    = 1'b1,
    parameter int unsigned WDOG_INIT  = 1000,
    localparam int         DW0        = (TIMER_W > PRESC_W) ? TIMER_W : PRESC_W,
    localparam int         DATA_W     = (DW0 < 5) ? 5 : DW0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [4:0]           wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [4:0]           rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [IRQ_LINES-1:0] irq_o,
    output logic                 wdog_o
);
    localparam int LAST = NUM_TIMERS - 1;

    logic               tick;
    logic [PRESC_W-1:0] psc_rl, psc_cnt;
    logic [TIMER_W-1:0] cnt_a  [NUM_TIMERS];
    logic [TIMER_W-1:0] rl_a   [NUM_TIMERS];
    tmr_ctrl_t          ctrl_a [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] pend_v, pulse_v, uf_v;

    mtu_prescaler #(.PW(PRESC_W), .RST_RELOAD(PRESC_RST)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .reload_we(wr_en && wr_addr == 5'd0),
        .reload_wdata(wr_data[PRESC_W-1:0]),
        .reload_q(psc_rl), .count_q(psc_cnt), .tick(tick)
    );

    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_chan
        logic sel;
        assign sel = wr_en && (wr_addr[4:2] == 3'(gi + 1));
        mtu_timer_chan #(
            .TW(TIMER_W), .IS_WDOG(WDOG_EN && gi == LAST), .WDOG_INIT(WDOG_INIT)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .cnt_we(sel && wr_addr[1:0] == 2'd0),
            .rl_we(sel && wr_addr[1:0] == 2'd1),
            .ctrl_we(sel && wr_addr[1:0] == 2'd2),
            .wdata(wr_data[TIMER_W-1:0]),
            .cnt_q(cnt_a[gi]), .rl_q(rl_a[gi]), .ctrl_q(ctrl_a[gi]),
            .pend_q(pend_v[gi]), .irq_pulse(pulse_v[gi]), .uf_now(uf_v[gi])
        );
    end

    // Read multiplexer over prescaler and channel registers.
    always_comb begin
        rd_data = '0;
        if (rd_addr == 5'd0) rd_data = DATA_W'(psc_rl);
        if (rd_addr == 5'd1) rd_data = DATA_W'(psc_cnt);
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (rd_addr[4:2] == 3'(i + 1)) begin
                case (rd_addr[1:0])
                    2'd0:    rd_data = DATA_W'(cnt_a[i]);
                    2'd1:    rd_data = DATA_W'(rl_a[i]);
                    2'd2:    rd_data = DATA_W'({pend_v[i], 1'b0, ctrl_a[i].irq_en,
                                                ctrl_a[i].auto_rl, ctrl_a[i].en});
                    default: rd_data = '0;
                endcase
            end
        end
    end

    // Map channel pulses onto separate or shared interrupt lines.
    always_comb begin
        irq_o = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (SEP_IRQ) irq_o[IRQ_BASE + i] = pulse_v[i];
            else         irq_o[IRQ_BASE]     = irq_o[IRQ_BASE] | pulse_v[i];
        end
    end

    // Sticky watchdog flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wdog_o <= 1'b0;
        else if (WDOG_EN && uf_v[LAST]) wdog_o <= 1'b1;
    end

    // R10
    wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_o |=> wdog_o);
    // R8
    irq_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !SEP_IRQ |-> $countones(irq_o) <= 1);
endmodule

// File: tb/multi_timer_unit_bench.sv
module multi_timer_unit_bench;
    localparam int NT = 3, TW = 16, PW = 8, PRST = 9, BASE = 4, LINES = 16, WDI = 40;
    localparam int TMASK = (1 << TW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, rd_data_s;
    logic [LINES-1:0] irq_o, irq_s;
    logic wdog_o, wdog_s;

    always #5 clk = ~clk;

    multi_timer_unit #(.PRESC_W(PW), .PRESC_RST(PRST), .NUM_TIMERS(NT), .TIMER_W(TW),
        .IRQ_LINES(LINES), .IRQ_BASE(BASE), .SEP_IRQ(1'b1), .WDOG_EN(1'b1), .WDOG_INIT(WDI))
    u_multi_timer_unit (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .wdog_o(wdog_o));

    multi_timer_unit #(.PRESC_W(PW), .PRESC_RST(PRST), .NUM_TIMERS(NT), .TIMER_W(TW),
        .IRQ_LINES(LINES), .IRQ_BASE(BASE), .SEP_IRQ(1'b0), .WDOG_EN(1'b1), .WDOG_INIT(WDI))
    u_multi_timer_unit_shared (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_s), .irq_o(irq_s), .wdog_o(wdog_s));

    int checks = 0, errors = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int pr_rl, pr_c, wd;
    int cnt [NT], rl [NT], en [NT], ar [NT], ie [NT], pend [NT], pulse [NT];

    always @(posedge clk) begin
        if (!rst_n) begin
            pr_rl = PRST; pr_c = PRST; wd = 0;
            for (int i = 0; i < NT; i++) begin
                cnt[i] = (i == NT-1) ? WDI : 0; rl[i] = cnt[i];
                en[i] = (i == NT-1); ar[i] = 0; ie[i] = 0; pend[i] = 0; pulse[i] = 0;
            end
        end else begin
            int tk, old_rl;
            tk = (pr_c == 0);
            old_rl = pr_rl;
            pr_c = tk ? old_rl : pr_c - 1;
            if (wr_en && wr_addr == 0) pr_rl = wr_data & 255;
            for (int i = 0; i < NT; i++) begin
                int uf, wc, wr, wk;
                uf = tk && en[i] && cnt[i] == 0;
                wc = wr_en && wr_addr == 5'(4*(i+1));
                wr = wr_en && wr_addr == 5'(4*(i+1)+1);
                wk = wr_en && wr_addr == 5'(4*(i+1)+2);
                pulse[i] = uf && ie[i];
                if (uf && i == NT-1) wd = 1;
                if (wc) cnt[i] = wr_data;
                else if (wk && wr_data[3]) cnt[i] = rl[i];
                else if (tk && en[i]) cnt[i] = (cnt[i] != 0) ? ((cnt[i] - 1) & TMASK) : (ar[i] ? rl[i] : 0);
                if (uf) pend[i] = 1;
                else if (wk && wr_data[4]) pend[i] = 0;
                if (wk) begin en[i] = wr_data[0]; ar[i] = wr_data[1]; ie[i] = wr_data[2]; end
                else if (uf && !ar[i]) en[i] = 0;
                if (wr) rl[i] = wr_data;
            end
        end
    end

    function automatic int model_rd(input int a);
        int t, s;
        if (a == 0) return pr_rl;
        if (a == 1) return pr_c;
        t = a / 4 - 1; s = a % 4;
        if (t < 0 || t >= NT) return 0;
        case (s)
            0: return cnt[t];
            1: return rl[t];
            2: return en[t] | (ar[t] << 1) | (ie[t] << 2) | (pend[t] << 4);
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int a, es, ep;
            string tg;
            a = int'(rd_addr);
            if (a < 2 || a >= 4*(NT+1)) tg = "R2";
            else if (a % 4 == 0) tg = "R3 R4 R11";
            else if (a % 4 == 1) tg = "R9";
            else tg = "R6";
            check(tg, int'(rd_data), model_rd(a));
            ep = 0; es = 0;
            for (int i = 0; i < NT; i++) begin
                ep |= pulse[i] << (BASE + i);
                if (pulse[i] != 0) es = 1 << BASE;
            end
            check("R7", int'(irq_o), ep);
            check("R8", int'(irq_s), es);
            check("R10", int'(wdog_o), wd);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            rd_addr = 5'(k % 16);
        end
    endtask

    task automatic chk_rd(input int a, input int exp, input string tag);
        @(negedge clk); #2;
        rd_addr = 5'(a); #1;
        check(tag, int'(rd_data), exp);
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        chk_rd(0, PRST, "R1");
        chk_rd(12, WDI, "R1");
        chk_rd(14, 1, "R1");
        chk_rd(6, 0, "R1");
        check("R1", int'(wdog_o), 0);
        check("R1", int'(irq_o), 0);
        // R2 faster prescaler
        wr(0, 3);
        chk_rd(0, 3, "R2");
        // R4 R7 auto-reload timer with interrupts
        wr(5, 5);
        wr(6, 5'b01111);
        idle(100);
        // R9 load strobe on a disabled timer, then direct count write
        wr(9, 700);
        wr(10, 5'b01000);
        chk_rd(8, 700, "R9");
        wr(8, 123);
        chk_rd(8, 123, "R9");
        idle(20);
        chk_rd(8, 123, "R3");
        // R5 one-shot
        wr(9, 4);
        wr(10, 5'b01101);
        idle(60);
        chk_rd(10, 5'b10100, "R5");
        chk_rd(8, 0, "R5");
        // R6 clear pending
        wr(10, 5'b10100);
        chk_rd(10, 5'b00100, "R6");
        // R11 count writes racing ticks
        for (int k = 0; k < 20; k++) wr(4, 2 + k % 3);
        // R7 interrupt-enable off: no pulses on timer 0 line
        wr(6, 5'b00011);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            check("R7", int'(irq_o[BASE]), 0);
        end
        // R10 watchdog fired and stays set after rearm writes
        check("R10", int'(wdog_o), 1);
        wr(12, 100);
        wr(14, 5'b00001);
        idle(30);
        check("R10", int'(wdog_o), 1);
        // R1 reset clears watchdog and reloads it
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk_rd(12, WDI, "R1");
        check("R1", int'(wdog_o), 0);
        idle(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule